// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits between a processor core and its memory system and decides, for every memory request, whether the access may proceed. Software programs up to eight protection regions. Each region is a naturally aligned power-of-two window that carries separate permission codes for instruction fetches and for data accesses, plus a cacheable flag and a bufferable flag. The block tests the request address against every enabled region at once. When several regions cover the address, the region with the highest index wins. The winner's permission code is then judged against the current processor mode and the access direction.

The result comes out one cycle after the request is accepted. It is either a grant or an abort, and an abort is tagged as a fetch abort or a data abort. The result also carries the winning region's index and its cache attributes, or a no-hit flag. Requests and results travel on valid/ready channels. A result stays on the output, unchanged, until the consumer takes it. While the result is stalled, `req_ready` is low, so no new request is taken. Region configuration arrives on flat, level-driven input vectors and is sampled at the edge where a request is accepted.

Top module: `prot_region_check`

## Requirements
- R1: Region k covers an address when the region is enabled and every address bit above bit N matches the stored base field, where N is the region's 5-bit size exponent and the region spans 2^(N+1) bytes. Base bits [31:12] of region k sit in `cfg_base[20k+19:20k]`. N is in `cfg_size[5k+4:5k]`. An exponent below 11 acts as 11 (4 KB).
- R2: A region with exponent 31 covers every address, whatever its base field holds.
- R3: When several enabled regions cover an address, the region with the highest index decides the result. This holds even when a lower region grants more privilege.
- R4: A region whose enable bit is 0 keeps its settings but never matches. Setting the bit again restores matching.
- R5: An address covered by no enabled region aborts with `rsp_nohit`=1 and `rsp_region`=0. A fetch gives `rsp_abort_fetch`; a data access gives `rsp_abort_data`. `rsp_cacheable` and `rsp_bufferable` are both 0.
- R6: Each 4-bit permission code is read as follows. 0000 denies everything. 0001 gives privileged read/write and no user access. 0010 gives privileged read/write and user read. 0011 gives read/write to both modes.
- R7: Code 0101 gives privileged read only and no user access. Code 0110 gives read only to both modes. Every other code (0100, 0111 to 1111) denies all access in both modes.
- R8: A fetch is judged as a read against the winner's instruction code (`cfg_iperm`), and `req_write` is ignored. A data access is judged against the winner's data code (`cfg_dperm`). A denied access aborts with the fetch/data tag; an allowed access sets `rsp_grant`. Exactly one of grant, fetch abort and data abort is set in each result.
- R9: On a hit, `rsp_region` holds the winner's index, and `rsp_cacheable`/`rsp_bufferable` hold the winner's attribute bits. This is true whether the access is granted or aborted.
- R10: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its result is valid after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, all result outputs hold still.
- R11: While `rst_n` is low, the block drives `rsp_valid` to 0 after the next edge, and no result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken by consumer |
| rsp_grant | output | 1 | Access allowed |
| rsp_abort_fetch | output | 1 | Fetch aborted |
| rsp_abort_data | output | 1 | Data access aborted |
| rsp_nohit | output | 1 | No enabled region covered the address |
| rsp_region | output | 3 | Index of the winning region |
| rsp_cacheable | output | 1 | Winner's cacheable attribute |
| rsp_bufferable | output | 1 | Winner's bufferable attribute |
| cfg_base | input | 160 | Per-region base address bits [31:12] |
| cfg_size | input | 40 | Per-region size exponent N |
| cfg_enable | input | 8 | Per-region enable |
| cfg_iperm | input | 32 | Per-region 4-bit instruction permission code |
| cfg_dperm | input | 32 | Per-region 4-bit data permission code |
| cfg_cacheable | input | 8 | Per-region cacheable bit |
| cfg_bufferable | input | 8 | Per-region bufferable bit |

## Verification
Each result is due exactly one rising edge after its request is accepted. The driver checks for `rsp_valid` at the first falling edge after acceptance, and at that point pushes the result it computed from the requirements into a queue. The monitor compares a result only on a falling edge where `rsp_valid` and `rsp_ready` are both high, which is one half-cycle before the edge where the consumer takes it. A stall test holds `rsp_ready` low for several cycles. It checks that the result stays put and `req_ready` stays low, and then that the result is released.

// File: rtl/prc_pkg.sv
`timescale 1ns/1ps
package prc_pkg;

  typedef struct packed {
    logic priv_rd;
    logic priv_wr;
    logic user_rd;
    logic user_wr;
  } perm_rights_t;

  // Unlisted codes grant nothing.
  function automatic perm_rights_t decode_perm(input logic [3:0] code);
    perm_rights_t r;
    r = '0;
    unique case (code)
      4'b0001: r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b0, user_wr: 1'b0};
      4'b0010: r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b0};
      4'b0011: r = '{priv_rd: 1'b1, priv_wr: 1'b1, user_rd: 1'b1, user_wr: 1'b1};
      4'b0101: r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b0, user_wr: 1'b0};
      4'b0110: r = '{priv_rd: 1'b1, priv_wr: 1'b0, user_rd: 1'b1, user_wr: 1'b0};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/prc_region_hit.sv
`timescale 1ns/1ps
module prc_region_hit #(
  parameter int ADDR_W = 32,
  parameter int LSB    = 12,
  parameter int SZ_W   = 5
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [ADDR_W-LSB-1:0] base,
  input  logic [SZ_W-1:0]       size_exp,
  input  logic                  enable,
  output logic                  hit
);
  logic mismatch;

  // Only bits above the size exponent take part in the compare.
  always_comb begin
    mismatch = 1'b0;
    for (int i = LSB; i < ADDR_W; i++) begin
      if ((i > int'(size_exp)) && (addr[i] != base[i-LSB])) mismatch = 1'b1;
    end
    hit = enable && !mismatch;
  end
endmodule

// File: rtl/prc_prio_pick.sv
`timescale 1ns/1ps
module prc_prio_pick #(
  parameter int NUM   = 8,
  parameter int IDX_W = 3
) (
  input  logic [NUM-1:0]   hits,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx
);
  // Later iterations override earlier ones: highest index wins.
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hits[i]) win_idx = IDX_W'(i);
    end
    any_hit = |hits;
  end
endmodule

// File: rtl/prc_perm_eval.sv
`timescale 1ns/1ps
module prc_perm_eval
  import prc_pkg::*;
#(
  parameter int AP_W = 4
) (
  input  logic [AP_W-1:0] code,
  input  logic            priv,
  input  logic            write,
  output logic            allow
);
  logic [3:0]   code4;
  perm_rights_t rights;

  generate
    if (AP_W == 2) begin : g_narrow
      assign code4 = {2'b00, code};
    end else begin : g_wide
      assign code4 = code[3:0];
    end
  endgenerate

  always_comb begin
    rights = decode_perm(code4);
    if (priv) allow = write ? rights.priv_wr : rights.priv_rd;
    else      allow = write ? rights.user_wr : rights.user_rd;
  end
endmodule

// File: rtl/prot_region_check.sv
`timescale 1ns/1ps
module prot_region_check #(
  parameter int NUM    = 8,
  parameter int ADDR_W = 32,
  parameter int LSB    = 12,
  parameter int SZ_W   = 5,
  parameter int AP_W   = 4,
  localparam int BASE_W = ADDR_W - LSB,
  localparam int IDX_W  = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_write,
  input  logic                   req_fetch,
  input  logic                   req_priv,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_grant,
  output logic                   rsp_abort_fetch,
  output logic                   rsp_abort_data,
  output logic                   rsp_nohit,
  output logic [IDX_W-1:0]       rsp_region,
  output logic                   rsp_cacheable,
  output logic                   rsp_bufferable,
  input  logic [NUM*BASE_W-1:0]  cfg_base,
  input  logic [NUM*SZ_W-1:0]    cfg_size,
  input  logic [NUM-1:0]         cfg_enable,
  input  logic [NUM*AP_W-1:0]    cfg_iperm,
  input  logic [NUM*AP_W-1:0]    cfg_dperm,
  input  logic [NUM-1:0]         cfg_cacheable,
  input  logic [NUM-1:0]         cfg_bufferable
);
  logic [NUM-1:0]   hits;
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  logic [AP_W-1:0]  win_code;
  logic             allow;
  logic             eff_write;
  logic             accept;

  generate
    for (genvar k = 0; k < NUM; k++) begin : g_region
      prc_region_hit #(.ADDR_W(ADDR_W), .LSB(LSB), .SZ_W(SZ_W)) u_hit (
        .addr     (req_addr),
        .base     (cfg_base[k*BASE_W +: BASE_W]),
        .size_exp (cfg_size[k*SZ_W +: SZ_W]),
        .enable   (cfg_enable[k]),
        .hit      (hits[k])
      );
    end
  endgenerate

  prc_prio_pick #(.NUM(NUM), .IDX_W(IDX_W)) u_pick (
    .hits    (hits),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  always_comb begin
    win_code  = req_fetch ? cfg_iperm[win_idx*AP_W +: AP_W]
                          : cfg_dperm[win_idx*AP_W +: AP_W];
    eff_write = req_write && !req_fetch;
  end

  prc_perm_eval #(.AP_W(AP_W)) u_perm (
    .code  (win_code),
    .priv  (req_priv),
    .write (eff_write),
    .allow (allow)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_grant       <= 1'b0;
      rsp_abort_fetch <= 1'b0;
      rsp_abort_data  <= 1'b0;
      rsp_nohit       <= 1'b0;
      rsp_region      <= '0;
      rsp_cacheable   <= 1'b0;
      rsp_bufferable  <= 1'b0;
    end else if (accept) begin
      rsp_valid       <= 1'b1;
      rsp_grant       <= any_hit && allow;
      rsp_abort_fetch <= req_fetch && !(any_hit && allow);
      rsp_abort_data  <= !req_fetch && !(any_hit && allow);
      rsp_nohit       <= !any_hit;
      rsp_region      <= any_hit ? win_idx : '0;
      rsp_cacheable   <= any_hit && cfg_cacheable[win_idx];
      rsp_bufferable  <= any_hit && cfg_bufferable[win_idx];
    end else if (rsp_ready) begin
      rsp_valid       <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_region_check_chk.sv
`timescale 1ns/1ps
module prot_region_check_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_fetch,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_grant,
  input logic             rsp_abort_fetch,
  input logic             rsp_abort_data,
  input logic             rsp_nohit,
  input logic [IDX_W-1:0] rsp_region,
  input logic             rsp_cacheable,
  input logic             rsp_bufferable
);
  // R11
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R10
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_grant, rsp_abort_fetch,
      rsp_abort_data, rsp_nohit, rsp_region, rsp_cacheable, rsp_bufferable})));

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_grant, rsp_abort_fetch, rsp_abort_data}));

  // R5
  nohit_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nohit) |-> (!rsp_grant && rsp_region == '0
      && !rsp_cacheable && !rsp_bufferable));

  // R5
  fetch_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_fetch) |=> !rsp_abort_data);

  // R5
  data_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_fetch) |=> !rsp_abort_fetch);
endmodule

bind prot_region_check prot_region_check_chk #(.IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_fetch       (req_fetch),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_grant       (rsp_grant),
  .rsp_abort_fetch (rsp_abort_fetch),
  .rsp_abort_data  (rsp_abort_data),
  .rsp_nohit       (rsp_nohit),
  .rsp_region      (rsp_region),
  .rsp_cacheable   (rsp_cacheable),
  .rsp_bufferable  (rsp_bufferable)
);

// File: tb/test_prot_region_check.sv
`timescale 1ns/1ps
module test_prot_region_check;
  localparam int NUM = 8;

  typedef struct packed {
    logic       grant;
    logic       abort_fetch;
    logic       abort_data;
    logic       nohit;
    logic [2:0] region;
    logic       cacheable;
    logic       bufferable;
  } result_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_priv = 1'b0;
  logic [31:0] req_addr = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, rsp_grant, rsp_abort_fetch, rsp_abort_data, rsp_nohit;
  logic [2:0] rsp_region;
  logic rsp_cacheable, rsp_bufferable;

  logic [19:0] m_base [NUM];
  logic [4:0]  m_size [NUM];
  logic [3:0]  m_ip   [NUM];
  logic [3:0]  m_dp   [NUM];
  logic [NUM-1:0] m_en, m_c, m_b;
  logic [NUM*20-1:0] cfg_base;
  logic [NUM*5-1:0]  cfg_size;
  logic [NUM*4-1:0]  cfg_iperm, cfg_dperm;

  always_comb begin
    for (int k = 0; k < NUM; k++) begin
      cfg_base[k*20 +: 20] = m_base[k];
      cfg_size[k*5 +: 5]   = m_size[k];
      cfg_iperm[k*4 +: 4]  = m_ip[k];
      cfg_dperm[k*4 +: 4]  = m_dp[k];
    end
  end

  always #10 clk = ~clk;

  prot_region_check i_prot_region_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_grant(rsp_grant),
    .rsp_abort_fetch(rsp_abort_fetch), .rsp_abort_data(rsp_abort_data),
    .rsp_nohit(rsp_nohit), .rsp_region(rsp_region), .rsp_cacheable(rsp_cacheable),
    .rsp_bufferable(rsp_bufferable), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_enable(m_en), .cfg_iperm(cfg_iperm), .cfg_dperm(cfg_dperm),
    .cfg_cacheable(m_c), .cfg_bufferable(m_b)
  );

  int checks = 0;
  int fails  = 0;
  result_t expq [$];
  string   tagq [$];

  function automatic logic rights_ok(input logic [3:0] code, input logic priv, input logic wr);
    case (code)
      4'd1:    return priv;
      4'd2:    return priv || !wr;
      4'd3:    return 1'b1;
      4'd5:    return priv && !wr;
      4'd6:    return !wr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic result_t predict(input logic [31:0] a, input logic f,
                                      input logic w, input logic p);
    result_t r;
    int win;
    int lo;
    win = -1;
    for (int k = 0; k < NUM; k++) begin
      lo = (m_size[k] < 11) ? 12 : int'(m_size[k]) + 1;
      if (m_en[k] && (lo >= 32 || (({m_base[k], 12'h000} >> lo) == (a >> lo)))) win = k;
    end
    r = '0;
    if (win < 0) begin
      r.nohit = 1'b1;
      r.abort_fetch = f;
      r.abort_data = !f;
    end else begin
      r.region = 3'(win);
      r.cacheable = m_c[win];
      r.bufferable = m_b[win];
      if (rights_ok(f ? m_ip[win] : m_dp[win], p, w && !f)) r.grant = 1'b1;
      else begin
        r.abort_fetch = f;
        r.abort_data = !f;
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] a, input logic f,
                      input logic w, input logic p);
    @(negedge clk);
    req_addr = a; req_fetch = f; req_write = w; req_priv = p; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    expq.push_back(predict(a, f, w, p));
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: result due one edge after acceptance
    check({tag, " R10 latency"}, rsp_valid === 1'b1, rsp_valid, 1);
  endtask

  // Monitor: compare on every handshake
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        result_t got, exp;
        string t;
        got = {rsp_grant, rsp_abort_fetch, rsp_abort_data, rsp_nohit,
               rsp_region, rsp_cacheable, rsp_bufferable};
        if (expq.size() == 0) begin
          check("R10 unexpected result", 1'b0, got, 0);
        end else begin
          exp = expq.pop_front();
          t = tagq.pop_front();
          check(t, got === exp, got, exp);
        end
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic clear_cfg();
    for (int k = 0; k < NUM; k++) begin
      m_base[k] = '0; m_size[k] = 5'd11; m_ip[k] = 4'd0; m_dp[k] = 4'd0;
    end
    m_en = '0; m_c = '0; m_b = '0;
  endtask

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset valid", rsp_valid === 1'b0, rsp_valid, 0);
    check("R11 reset ready", req_ready === 1'b1, req_ready, 1);
    rst_n = 1'b1;

    // 256 KB user region 0 with a 32 KB privileged region 1 laid over it
    m_base[0] = 20'h00000; m_size[0] = 5'd17; m_ip[0] = 4'd3; m_dp[0] = 4'd3;
    m_en[0] = 1'b1; m_c[0] = 1'b1;
    m_base[1] = 20'h00000; m_size[1] = 5'd14; m_ip[1] = 4'd1; m_dp[1] = 4'd1;
    m_en[1] = 1'b1; m_b[1] = 1'b1;

    send("R3 user read in overlap aborts", 32'h0000_1000, 1'b0, 1'b0, 1'b0);
    send("R9 priv write in overlap", 32'h0000_1000, 1'b0, 1'b1, 1'b1);
    send("R1 user write past small window", 32'h0001_0000, 1'b0, 1'b1, 1'b0);
    send("R1 last byte of 256KB", 32'h0003_FFFC, 1'b0, 1'b0, 1'b0);
    send("R5 fetch outside all", 32'h0004_0000, 1'b1, 1'b0, 1'b1);
    send("R5 data outside all", 32'h0004_0000, 1'b0, 1'b1, 1'b1);

    // R4: disable region 1, then re-enable
    m_en[1] = 1'b0;
    send("R4 disabled region skipped", 32'h0000_1000, 1'b0, 1'b0, 1'b0);
    m_en[1] = 1'b1;
    send("R4 re-enabled region matches", 32'h0000_1000, 1'b0, 1'b0, 1'b0);

    // R2, R8: full-space region 2 with a junk base field
    m_base[2] = 20'h12345; m_size[2] = 5'd31; m_ip[2] = 4'd6; m_dp[2] = 4'd0;
    m_en[2] = 1'b1; m_c[2] = 1'b1; m_b[2] = 1'b1;
    send("R2 full space fetch user", 32'hF000_0000, 1'b1, 1'b0, 1'b0);
    send("R8 fetch ignores write flag", 32'hF000_0000, 1'b1, 1'b1, 1'b0);
    send("R8 data uses data code", 32'hF000_0000, 1'b0, 1'b0, 1'b1);
    send("R3 high region beats low", 32'h0000_1000, 1'b0, 1'b1, 1'b1);

    // R7: extended codes on data side
    m_dp[2] = 4'd5;
    send("R7 0101 priv read", 32'h8000_0000, 1'b0, 1'b0, 1'b1);
    send("R7 0101 priv write", 32'h8000_0000, 1'b0, 1'b1, 1'b1);
    send("R7 0101 user read", 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    m_dp[2] = 4'd6;
    send("R7 0110 user read", 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    send("R7 0110 user write", 32'h8000_0000, 1'b0, 1'b1, 1'b0);
    m_dp[2] = 4'd7;
    send("R7 undefined code priv read", 32'h8000_0000, 1'b0, 1'b0, 1'b1);
    m_dp[2] = 4'd4;
    send("R7 0100 priv read", 32'h8000_0000, 1'b0, 1'b0, 1'b1);
    m_en[2] = 1'b0;

    // R1, R6: 256 KB region 5 at 0x300000 with code 0010
    m_base[5] = 20'h00300; m_size[5] = 5'd17; m_dp[5] = 4'd2; m_en[5] = 1'b1; m_c[5] = 1'b1;
    send("R1 inside aligned window", 32'h0033_FFFC, 1'b0, 1'b0, 1'b0);
    send("R1 just past window", 32'h0034_0000, 1'b0, 1'b0, 1'b0);
    send("R6 0010 user write", 32'h0030_0000, 1'b0, 1'b1, 1'b0);
    send("R6 0010 priv write", 32'h0030_0000, 1'b0, 1'b1, 1'b1);
    m_dp[5] = 4'd0;
    send("R6 0000 priv read", 32'h0030_0000, 1'b0, 1'b0, 1'b1);

    // R10: stall the result channel
    @(negedge clk);
    rsp_ready = 1'b0;
    send("R10 stalled result", 32'h0000_2000, 1'b0, 1'b0, 1'b1);
    begin
      logic [7:0] snap;
      snap = {rsp_grant, rsp_abort_fetch, rsp_abort_data, rsp_nohit,
              rsp_region, rsp_cacheable};
      repeat (3) @(negedge clk);
      check("R10 held valid", rsp_valid === 1'b1, rsp_valid, 1);
      check("R10 ready low while stalled", req_ready === 1'b0, req_ready, 0);
      check("R10 outputs stable", snap === {rsp_grant, rsp_abort_fetch, rsp_abort_data,
            rsp_nohit, rsp_region, rsp_cacheable}, rsp_region, snap[3:1]);
    end
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 released", rsp_valid === 1'b0, rsp_valid, 0);

    repeat (3) @(negedge clk);
    check("R10 queue drained", expq.size() == 0, expq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule